// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block drives one gate-open line per transmit queue from a gate control list that repeats forever with a fixed period. Each list entry carries a command, a gate bitmask and a duration in nanoseconds. Software loads the entries, an absolute start time and the period through a simple write port. It then enables the schedule. The block compares a free-running nanosecond time input against the start time and the end time of the current entry. It steps through the list as each duration runs out and restarts from the first entry at every period boundary.

Entries can also raise or drop a preemption hold request. This lets express traffic go ahead while the queues marked as preemptible are held back. The preemptible-queue mask is written along with the control word and is presented at an output for the transmit logic. While no schedule is running, every gate is open and no hold is requested.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset every gate is open, `hold_req` and `sched_run` are 0, and `preemptible` reads all ones except bit 0, so queue 0 is express.
- R2: A write with `cfg_sel`=0 stores into entry `cfg_idx` the command `cfg_cmd`, the mask `cfg_mask` and the duration `cfg_data[IVL_W-1:0]`. While an entry is active, bit i of `gate_open` equals bit i of its mask, so a mask of 0 closes all gates.
- R3: A control write (`cfg_sel`=3, `cfg_data[0]`=1) made before the start time (`cfg_sel`=1) keeps all gates open until then. The first nonzero-duration entry appears, with `sched_run` set, on the clock edge at which `now_ns` first reaches the start time.
- R4: The gates change to the next entry on the same clock edge at which `now_ns` reaches the end of the current entry.
- R5: The list repeats with the period written with `cfg_sel`=2, starting again from the first entry at each period boundary. The period must equal the sum of the durations of the used entries.
- R6: An entry whose duration is 0 never drives the gates and never changes the hold request.
- R7: If the start time has already passed when the schedule is enabled, the schedule begins at the first start time plus a whole number of periods that is at or after the current time. The gates stay open until then.
- R8: A command code of 1 (hold) sets `hold_req`, 2 (release) clears it, and 0 (set) leaves it unchanged. `hold_req` is 0 when a schedule begins.
- R9: A control write with `cfg_data[0]`=0 opens every gate and clears `hold_req` and `sched_run` on the next edge.
- R10: Each control write loads `cfg_mask` into `preemptible`.
- R11: Only entries 0 up to the last index (`cfg_idx` of the control write) are used. Higher entries have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_ns | input | TIME_W | Free-running time in nanoseconds |
| cfg_we | input | 1 | Write strobe |
| cfg_sel | input | 2 | Target: 0 entry, 1 start time, 2 period, 3 control |
| cfg_idx | input | log2(DEPTH) | Entry index, or last used index on control |
| cfg_cmd | input | 2 | Entry command: 0 set, 1 hold, 2 release |
| cfg_mask | input | NQ | Entry gate mask, or preemptible mask on control |
| cfg_data | input | TIME_W | Duration, start time, period, or enable in bit 0 |
| gate_open | output | NQ | Gate open per queue |
| hold_req | output | 1 | Preemption hold request |
| preemptible | output | NQ | Queues that may be preempted |
| sched_run | output | 1 | Schedule executing |

## Verification
A wrong entry index or a wrong entry end time shows up on `gate_open` at the very next boundary edge. It then stays wrong for the whole slot and usually for the rest of the cycle, so the bench compares every clock against a position computed as (now − start) modulo period. A corrupted hold state shows on `hold_req` only until the next hold or release entry. For that reason the lists place such commands both right after a skipped zero-length entry and at the wrap. Start-time alignment errors show as gates closing one period too early or late, which the late-enable case exposes within two edges.

// File: rtl/tas_pkg.sv
package tas_pkg;

  typedef enum logic [1:0] {
    CMD_SET  = 2'd0,
    CMD_HOLD = 2'd1,
    CMD_REL  = 2'd2,
    CMD_RSV  = 2'd3
  } gcl_cmd_e;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_CYCLE = 2'd2,
    SEL_CTRL  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIND = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } seq_st_e;

  // Hold request after applying an entry command to the current hold state.
  function automatic logic hold_after(input logic [1:0] cmd, input logic cur);
    logic res;
    case (cmd)
      CMD_HOLD: res = 1'b1;
      CMD_REL:  res = 1'b0;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/tas_entry_pick.sv
module tas_entry_pick #(
  parameter int DEPTH = 8,
  parameter int IVL_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][IVL_W-1:0] ivl,
  input  logic [IDX_W:0]              from_idx,
  input  logic [IDX_W-1:0]            last_idx,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);

  logic [DEPTH-1:0] cand;

  // An entry qualifies when it lies inside the search window and has a time slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cand
    assign cand[g] = ((IDX_W+1)'(g) >= from_idx) &&
                     (IDX_W'(g) <= last_idx) &&
                     (ivl[g] != '0);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    // R6: a selected entry always has a nonzero duration
    p_pick_nonzero_r6: assert (!found || (ivl[idx] != '0));
    // R11: a selected entry never lies beyond the last used index
    p_pick_window_r11: assert (!found || (idx <= last_idx));
  end

endmodule

// File: rtl/tas_gcl_store.sv
module tas_gcl_store
  import tas_pkg::*;
#(
  parameter int NQ     = 8,
  parameter int DEPTH  = 8,
  parameter int TIME_W = 48,
  parameter int IVL_W  = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [1:0]                  wr_cmd,
  input  logic [NQ-1:0]               wr_mask,
  input  logic [TIME_W-1:0]           wr_data,
  output logic [DEPTH-1:0][1:0]       ent_cmd,
  output logic [DEPTH-1:0][NQ-1:0]    ent_mask,
  output logic [DEPTH-1:0][IVL_W-1:0] ent_ivl,
  output logic [TIME_W-1:0]           base_q,
  output logic [TIME_W-1:0]           cycle_q,
  output logic [IDX_W-1:0]            last_q,
  output logic [NQ-1:0]               pmask_q,
  output logic                        arm,
  output logic                        stop
);

  localparam logic [NQ-1:0] PMASK_RST = {{(NQ-1){1'b1}}, 1'b0};

  logic base_en, cycle_en, ctrl_en;
  logic [DEPTH-1:0] ent_we;

  assign base_en  = wr_en && (wr_sel == SEL_BASE);
  assign cycle_en = wr_en && (wr_sel == SEL_CYCLE);
  assign ctrl_en  = wr_en && (wr_sel == SEL_CTRL);
  assign arm      = ctrl_en && wr_data[0];
  assign stop     = ctrl_en && !wr_data[0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [1:0]       cmd_q;
    logic [NQ-1:0]    mask_q;
    logic [IVL_W-1:0] ivl_q;

    assign ent_we[g] = wr_en && (wr_sel == SEL_ENTRY) && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q  <= '0;
        mask_q <= '0;
        ivl_q  <= '0;
      end else if (ent_we[g]) begin
        cmd_q  <= wr_cmd;
        mask_q <= wr_mask;
        ivl_q  <= wr_data[IVL_W-1:0];
      end
    end

    assign ent_cmd[g]  = cmd_q;
    assign ent_mask[g] = mask_q;
    assign ent_ivl[g]  = ivl_q;

    p_entry_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ent_we[g] |=> (ivl_q == $past(wr_data[IVL_W-1:0])) && (mask_q == $past(wr_mask)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_en) base_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycle_q <= '0;
    else if (cycle_en) cycle_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      pmask_q <= PMASK_RST;
    end else if (ctrl_en) begin
      last_q  <= wr_idx;
      pmask_q <= wr_mask;
    end
  end

  p_pmask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> pmask_q == $past(wr_mask));

endmodule

// File: rtl/tas_gate_seq.sv
module tas_gate_seq
  import tas_pkg::*;
#(
  parameter int NQ     = 8,
  parameter int DEPTH  = 8,
  parameter int TIME_W = 48,
  parameter int IVL_W  = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TIME_W-1:0]           now,
  input  logic                        arm,
  input  logic                        stop,
  input  logic [TIME_W-1:0]           base,
  input  logic [TIME_W-1:0]           cycle,
  input  logic [IDX_W-1:0]            last,
  input  logic [DEPTH-1:0][1:0]       ent_cmd,
  input  logic [DEPTH-1:0][NQ-1:0]    ent_mask,
  input  logic [DEPTH-1:0][IVL_W-1:0] ent_ivl,
  output logic [NQ-1:0]               gate,
  output logic                        hold,
  output logic                        running
);

  seq_st_e          st_q, st_d;
  logic [TIME_W-1:0] start_q, start_d;
  logic [TIME_W-1:0] end_q, end_d;
  logic [IDX_W-1:0]  cur_q, cur_d;
  logic [NQ-1:0]     gate_q, gate_d;
  logic              hold_q, hold_d;

  logic              adv_found, wrap_found;
  logic [IDX_W-1:0]  adv_idx, wrap_idx;
  logic [IDX_W:0]    adv_from;
  logic              do_launch;
  logic [TIME_W-1:0] launch_at;
  logic              hold_seed;

  assign adv_from = (IDX_W+1)'(cur_q) + (IDX_W+1)'(1);

  // Next slot inside the current cycle
  tas_entry_pick #(.DEPTH(DEPTH), .IVL_W(IVL_W)) u_pick_adv (
    .ivl      (ent_ivl),
    .from_idx (adv_from),
    .last_idx (last),
    .found    (adv_found),
    .idx      (adv_idx)
  );

  // First slot of a cycle
  tas_entry_pick #(.DEPTH(DEPTH), .IVL_W(IVL_W)) u_pick_wrap (
    .ivl      (ent_ivl),
    .from_idx ('0),
    .last_idx (last),
    .found    (wrap_found),
    .idx      (wrap_idx)
  );

  always_comb begin
    st_d      = st_q;
    start_d   = start_q;
    end_d     = end_q;
    cur_d     = cur_q;
    gate_d    = gate_q;
    hold_d    = hold_q;
    do_launch = 1'b0;
    launch_at = start_q;
    hold_seed = (st_q == ST_RUN) ? hold_q : 1'b0;

    case (st_q)
      ST_FIND: begin
        if (start_q < now)       start_d   = start_q + cycle;
        else if (start_q == now) do_launch = 1'b1;
        else                     st_d      = ST_WAIT;
      end
      ST_WAIT: begin
        if (now >= start_q) do_launch = 1'b1;
      end
      ST_RUN: begin
        if (now >= end_q) begin
          if (adv_found) begin
            cur_d  = adv_idx;
            end_d  = end_q + TIME_W'(ent_ivl[adv_idx]);
            gate_d = ent_mask[adv_idx];
            hold_d = hold_after(ent_cmd[adv_idx], hold_q);
          end else begin
            do_launch = 1'b1;
            launch_at = start_q + cycle;
          end
        end
      end
      default: ;
    endcase

    if (do_launch) begin
      st_d    = ST_RUN;
      start_d = launch_at;
      cur_d   = wrap_idx;
      end_d   = launch_at + TIME_W'(ent_ivl[wrap_idx]);
      gate_d  = ent_mask[wrap_idx];
      hold_d  = hold_after(ent_cmd[wrap_idx], hold_seed);
    end

    if (stop) begin
      st_d   = ST_IDLE;
      gate_d = '1;
      hold_d = 1'b0;
    end else if (arm) begin
      st_d    = ST_FIND;
      start_d = base;
      gate_d  = '1;
      hold_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
      gate_q  <= '1;
      hold_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      end_q   <= end_d;
      cur_q   <= cur_d;
      gate_q  <= gate_d;
      hold_q  <= hold_d;
    end
  end

  assign gate    = gate_q;
  assign hold    = hold_q;
  assign running = (st_q == ST_RUN);

  p_idle_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> ((gate_q == '1) && !hold_q));

  p_stop_opens_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ((gate_q == '1) && !hold_q && (st_q == ST_IDLE)));

  p_cur_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> (cur_q <= last));

  p_boundary_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && (now >= end_q) && adv_found && !arm && !stop)
      |=> (cur_q != $past(cur_q)));

  p_launch_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && (now >= start_q) && !arm && !stop) |=> (st_q == ST_RUN));

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
  import tas_pkg::*;
#(
  parameter int NQ     = 8,
  parameter int DEPTH  = 8,
  parameter int TIME_W = 48,
  parameter int IVL_W  = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_ns,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_cmd,
  input  logic [NQ-1:0]     cfg_mask,
  input  logic [TIME_W-1:0] cfg_data,
  output logic [NQ-1:0]     gate_open,
  output logic              hold_req,
  output logic [NQ-1:0]     preemptible,
  output logic              sched_run
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // Reset asserts at once and leaves two edges after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DEPTH-1:0][1:0]       ent_cmd;
  logic [DEPTH-1:0][NQ-1:0]    ent_mask;
  logic [DEPTH-1:0][IVL_W-1:0] ent_ivl;
  logic [TIME_W-1:0]           base_q, cycle_q;
  logic [IDX_W-1:0]            last_q;
  logic [NQ-1:0]               pmask_q;
  logic                        arm, stop;

  tas_gcl_store #(
    .NQ(NQ), .DEPTH(DEPTH), .TIME_W(TIME_W), .IVL_W(IVL_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_idx   (cfg_idx),
    .wr_cmd   (cfg_cmd),
    .wr_mask  (cfg_mask),
    .wr_data  (cfg_data),
    .ent_cmd  (ent_cmd),
    .ent_mask (ent_mask),
    .ent_ivl  (ent_ivl),
    .base_q   (base_q),
    .cycle_q  (cycle_q),
    .last_q   (last_q),
    .pmask_q  (pmask_q),
    .arm      (arm),
    .stop     (stop)
  );

  tas_gate_seq #(
    .NQ(NQ), .DEPTH(DEPTH), .TIME_W(TIME_W), .IVL_W(IVL_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .now      (now_ns),
    .arm      (arm),
    .stop     (stop),
    .base     (base_q),
    .cycle    (cycle_q),
    .last     (last_q),
    .ent_cmd  (ent_cmd),
    .ent_mask (ent_mask),
    .ent_ivl  (ent_ivl),
    .gate     (gate_open),
    .hold     (hold_req),
    .running  (sched_run)
  );

  assign preemptible = pmask_q;

endmodule

// File: tb/tas_gate_sched_test.sv
module tas_gate_sched_test;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 10;
  localparam int NQ         = 8;
  localparam int DEPTH      = 8;
  localparam int TIME_W     = 48;
  localparam int IVL_W      = 32;
  localparam int IDX_W      = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [TIME_W-1:0] now_ns;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [IDX_W-1:0]  cfg_idx;
  logic [1:0]        cfg_cmd;
  logic [NQ-1:0]     cfg_mask;
  logic [TIME_W-1:0] cfg_data;
  logic [NQ-1:0]     gate_open;
  logic              hold_req;
  logic [NQ-1:0]     preemptible;
  logic              sched_run;

  always #(CLK_PERIOD/2) clk = ~clk;

  tas_gate_sched #(.NQ(NQ), .DEPTH(DEPTH), .TIME_W(TIME_W), .IVL_W(IVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .now_ns(now_ns),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_cmd(cfg_cmd),
    .cfg_mask(cfg_mask), .cfg_data(cfg_data),
    .gate_open(gate_open), .hold_req(hold_req), .preemptible(preemptible),
    .sched_run(sched_run)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  int     b_cmd [DEPTH];
  int     b_mask[DEPTH];
  longint b_ivl [DEPTH];
  int     b_last = 0;
  longint b_cycle = 1;
  longint b_start = 0;
  bit     armed = 1'b0;
  logic [NQ-1:0] b_pm = 8'hFE;
  longint t_now = 0;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired: run=%b expected completion", sched_run);
    report();
    $finish;
  end

  // Expected outputs from the position inside the cycle at the edge's time value
  task automatic check_sched(input string tag);
    logic [NQ-1:0] eg;
    logic eh, er;
    longint p, k, cum;
    int sel;
    bit fnd;
    eg = '1; eh = 1'b0; er = 1'b0;
    if (armed && t_now >= b_start) begin
      er  = 1'b1;
      p   = (t_now - b_start) % b_cycle;
      k   = (t_now - b_start) / b_cycle;
      cum = 0;
      sel = 0;
      for (int i = 0; i <= b_last; i++) begin
        if (b_ivl[i] > 0 && p >= cum && p < cum + b_ivl[i]) sel = i;
        cum += b_ivl[i];
      end
      eg  = NQ'(b_mask[sel]);
      fnd = 1'b0;
      for (int j = sel; j >= 0; j--)
        if (!fnd && b_ivl[j] > 0 && (b_cmd[j] == 1 || b_cmd[j] == 2)) begin
          eh = (b_cmd[j] == 1); fnd = 1'b1;
        end
      if (!fnd && k > 0)
        for (int j = b_last; j > sel; j--)
          if (!fnd && b_ivl[j] > 0 && (b_cmd[j] == 1 || b_cmd[j] == 2)) begin
            eh = (b_cmd[j] == 1); fnd = 1'b1;
          end
    end
    n_cmp++;
    if (gate_open !== eg || hold_req !== eh || sched_run !== er) begin
      n_bad++;
      $display("FAIL %s now=%0d gate=%h exp %h hold=%b exp %b run=%b exp %b",
               tag, t_now, gate_open, eg, hold_req, eh, sched_run, er);
    end
  endtask

  task automatic check_pm(input logic [NQ-1:0] exp, input string tag);
    n_cmp++;
    if (preemptible !== exp) begin
      n_bad++;
      $display("FAIL %s preemptible=%h exp %h", tag, preemptible, exp);
    end
  endtask

  task automatic edge_step(input bit chk, input string tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (chk) check_sched(tag);
    cfg_we = 1'b0;
    t_now += STEP;
    now_ns = t_now[TIME_W-1:0];
  endtask

  task automatic wr_entry(input int idx, input int cmd, input int mask, input longint ivl);
    b_cmd[idx] = cmd; b_mask[idx] = mask; b_ivl[idx] = ivl;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = IDX_W'(idx);
    cfg_cmd = 2'(cmd); cfg_mask = NQ'(mask); cfg_data = TIME_W'(ivl);
    edge_step(1'b0, "");
  endtask

  task automatic wr_word(input int sel, input longint val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = TIME_W'(val);
    edge_step(1'b0, "");
  endtask

  task automatic arm_sched(input longint off, input longint cyc, input int last,
                           input logic [NQ-1:0] pm, input string tag);
    longint base, f;
    b_cycle = cyc;
    wr_word(2, cyc);
    base = t_now + off;
    wr_word(1, base);
    b_last = last;
    b_pm   = pm;
    f = t_now + STEP;
    if (f <= base) b_start = base;
    else           b_start = base + ((f - base + cyc - 1) / cyc) * cyc;
    armed = 1'b1;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_idx = IDX_W'(last);
    cfg_mask = pm; cfg_data = TIME_W'(1);
    edge_step(1'b1, tag);
  endtask

  task automatic stop_sched(input string tag);
    armed = 1'b0;
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_idx = IDX_W'(b_last);
    cfg_mask = b_pm; cfg_data = '0;
    edge_step(1'b1, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin b_cmd[i] = 0; b_mask[i] = 0; b_ivl[i] = 0; end
    rst_n = 1'b0; now_ns = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0;
    cfg_cmd = '0; cfg_mask = '0; cfg_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) edge_step(1'b0, "");

    // R1: reset state
    edge_step(1'b1, "R1");
    check_pm(8'hFE, "R1");

    // R2: sweep of single-bit masks on a one-entry list
    for (int q = 0; q < NQ; q++) begin
      wr_entry(0, 0, 1 << q, 20);
      arm_sched(20, 20, 0, 8'hFE, "R2");
      repeat (6) edge_step(1'b1, "R2");
      stop_sched("R9");
    end

    // Main list: zero-length hold entry, closed slot, release, unused tail (R11)
    wr_entry(0, 0, 8'h01, 40);
    wr_entry(1, 1, 8'h81, 0);
    wr_entry(2, 1, 8'h06, 30);
    wr_entry(3, 0, 8'h00, 20);
    wr_entry(4, 2, 8'hF0, 50);
    wr_entry(5, 1, 8'h5A, 30);
    wr_entry(6, 0, 8'h3C, 10);
    wr_entry(7, 2, 8'h0F, 20);
    arm_sched(100, 140, 4, 8'hFE, "R3");
    repeat (12) edge_step(1'b1, "R3");
    repeat (14) edge_step(1'b1, "R4,R6,R8");
    repeat (30) edge_step(1'b1, "R5,R8");
    stop_sched("R9");
    repeat (3) edge_step(1'b1, "R9");

    // R7: enabled after the start time has passed
    arm_sched(-60, 140, 4, 8'hFE, "R7");
    repeat (40) edge_step(1'b1, "R7");
    stop_sched("R9");

    // R6 and R11: zero-length first entry, entry 3 beyond the last index
    wr_entry(0, 1, 8'h11, 0);
    wr_entry(1, 2, 8'h22, 20);
    wr_entry(2, 0, 8'h44, 10);
    wr_entry(3, 0, 8'h99, 30);
    arm_sched(50, 30, 2, 8'h0C, "R11");
    check_pm(8'h0C, "R10");
    repeat (30) edge_step(1'b1, "R6,R11");
    stop_sched("R9");
    check_pm(8'h0C, "R10");

    report();
    $finish;
  end

endmodule